// File: doc/BRIEF.md
# Processor Exception Vector Unit

This unit steers a small 32-bit pipelined processor through reset and hardware traps. It watches two active-high reset requests and a vector of per-instruction fault flags raised by the execute stage. When a reset request has been held long enough, or when an enabled fault is raised while no trap is in progress, it flushes the pipeline and points instruction fetch at the proper vector.

For a trap, it also writes a return address to the link register. That address depends on the fault class. Translation and storage faults resume by re-executing the faulting instruction. Every other fault resumes at the next instruction. Both rules correct for an instruction sitting in a branch delay slot.

On reset it pulses an initialise strobe for the special registers. The rest of the processor uses this strobe to clear the fault address, floating-point status, process ID, zone protection, TLB index and any load/store reservation. The unit also offers the status word's reset value. It keeps its own exception status: a fault code, a delay-slot bit and an in-progress flag that masks further traps until software acknowledges it.

Top module: `exc_vector_unit`

## Requirements
- R1: Reset is accepted only after `rst_a` OR `rst_b` has been sampled high on 16 consecutive rising edges. A shorter run followed by a low cycle changes no output.
- R2: On the edge after each accepted-reset cycle, `flush`=1, `fetch_addr`=`BASE_VEC`, `spr_init`=1, `link_we`=0, `exc_busy`=0, `esr_code`=0 and `esr_dslot`=0, and `msr_init` equals `MSR_RESET`. Fault requests during those cycles are ignored.
- R3: An enabled fault accepted in a cycle gives, on the next edge, `flush`=1, `fetch_addr`=`BASE_VEC`+0x20 and `link_we`=1 with `link_data` set.
- R4: Of simultaneous requests, the lowest bit index wins. That index is stored in `esr_code`. The bit map is: 0 instr TLB miss, 1 instr storage, 2 instr bus error, 3 illegal opcode, 4 data TLB miss, 5 data storage, 6 data bus error, 7 unaligned, 8 divide, 9 FP underflow, 10 FP overflow, 11 FP divide-by-zero, 12 FP invalid, 13 FP denormal.
- R5: For classes 0, 1, 4 and 5, `link_data` is `ex_pc`, or `ex_pc`-4 when `ex_imm` is set. In a delay slot it is instead `ex_pc`-4, or `ex_pc`-8 when `ex_br_imm` is set.
- R6: For all other classes, `link_data` is `ex_pc`+4 and `ex_imm` has no effect. In a delay slot it is `ex_pc`-4, or `ex_pc`-8 when `ex_br_imm` is set.
- R7: While `exc_busy` is 1, requests cause no flush and leave `esr_code` unchanged. A high `exc_ack` clears `exc_busy` on the next edge.
- R8: `esr_dslot` takes the value of `ex_dslot` for the accepted fault.
- R9: Source 8 traps only when `HAS_DIV` is set, sources 9 to 13 only when `HAS_FPU` is set, and sources 0, 1, 4 and 5 only when `HAS_MMU` is set. A disabled source alone causes no flush and does not set `exc_busy`.
- R10: In a cycle with no accepted fault or reset, the next edge shows `flush`=0 and `link_we`=0, and `fetch_addr` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_a | input | 1 | External reset request A, active high |
| rst_b | input | 1 | External reset request B, active high |
| exc_req | input | 14 | Fault flags from the execute stage, bit map in R4 |
| ex_pc | input | 32 | Address of the execute-stage instruction |
| ex_dslot | input | 1 | Execute-stage instruction sits in a branch delay slot |
| ex_imm | input | 1 | Execute-stage instruction is preceded by an immediate prefix |
| ex_br_imm | input | 1 | The owning branch is preceded by an immediate prefix |
| exc_ack | input | 1 | Software clears the in-progress flag |
| flush | output | 1 | Pipeline flush |
| fetch_addr | output | 32 | Redirected fetch address |
| link_we | output | 1 | Write enable for the link register |
| link_data | output | 32 | Return address for the link register |
| spr_init | output | 1 | Initialise strobe for the special registers |
| msr_init | output | 32 | Reset value of the machine status word |
| exc_busy | output | 1 | Trap in progress |
| esr_code | output | 4 | Code of the accepted fault |
| esr_dslot | output | 1 | Accepted fault was in a delay slot |

## Verification
Every trap result appears on the edge after the cycle its request was applied. This covers the flush, vector, link write and status fields. The reset response appears on the edge after the sixteenth consecutive high sample, and it repeats for as long as the request stays high. The bench drives each stimulus on a falling edge and queues the expectation for that cycle. A monitor pops one expectation per rising edge and samples 1 ns after that edge. Each comparison therefore lands on exactly the edge where the registered outputs change.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter logic [31:0] BASE_VEC  = 32'h0000_0000,
  parameter logic [31:0] MSR_RESET = 32'h0000_0000,
  parameter int          RST_HOLD  = 16,
  parameter bit          HAS_DIV   = 1'b0,
  parameter bit          HAS_FPU   = 1'b1,
  parameter bit          HAS_MMU   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_a,
  input  logic        rst_b,
  input  logic [13:0] exc_req,
  input  logic [31:0] ex_pc,
  input  logic        ex_dslot,
  input  logic        ex_imm,
  input  logic        ex_br_imm,
  input  logic        exc_ack,
  output logic        flush,
  output logic [31:0] fetch_addr,
  output logic        link_we,
  output logic [31:0] link_data,
  output logic        spr_init,
  output logic [31:0] msr_init,
  output logic        exc_busy,
  output logic [3:0]  esr_code,
  output logic        esr_dslot
);
  localparam int NSRC = 14;
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(RST_HOLD);
  localparam logic [NSRC-1:0] MMU_SET = 14'b00_0000_0011_0011;
  localparam logic [NSRC-1:0] EN_MASK = {{5{HAS_FPU}}, HAS_DIV, 2'b11,
                                         HAS_MMU, HAS_MMU, 2'b11, HAS_MMU, HAS_MMU};
  localparam logic [31:0] TRAP_VEC = BASE_VEC + 32'h20;

  logic [CW-1:0]   hold_cnt;
  logic [NSRC-1:0] req_v;
  logic [3:0]      win;
  logic            win_mmu;
  logic            rst_any, rst_take, hit;
  logic [31:0]     branch_ret, ret_addr;

  assign rst_any  = rst_a | rst_b;
  assign rst_take = rst_any && (hold_cnt >= HOLD_MAX - 1'b1);
  assign req_v    = exc_req & EN_MASK;
  assign hit      = (|req_v) && !exc_busy && !rst_take;
  assign msr_init = MSR_RESET;

  always_comb begin
    win = '0;
    win_mmu = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req_v[i]) begin
        win = 4'(i);
        win_mmu = MMU_SET[i];
      end
  end

  assign branch_ret = ex_br_imm ? ex_pc - 32'd8 : ex_pc - 32'd4;
  assign ret_addr   = ex_dslot ? branch_ret :
                      win_mmu  ? (ex_imm ? ex_pc - 32'd4 : ex_pc) :
                                 ex_pc + 32'd4;

  always_ff @(posedge clk) begin
    if (!rst_any)              hold_cnt <= '0;
    else if (hold_cnt != HOLD_MAX) hold_cnt <= hold_cnt + 1'b1;

    flush    <= rst_take | hit;
    link_we  <= hit;
    spr_init <= rst_take;

    if (rst_take)  fetch_addr <= BASE_VEC;
    else if (hit)  fetch_addr <= TRAP_VEC;

    if (hit) link_data <= ret_addr;

    if (rst_take) begin
      exc_busy  <= 1'b0;
      esr_code  <= '0;
      esr_dslot <= 1'b0;
    end else if (hit) begin
      exc_busy  <= 1'b1;
      esr_code  <= win;
      esr_dslot <= ex_dslot;
    end else if (exc_ack) begin
      exc_busy  <= 1'b0;
    end
  end
endmodule

module exc_vector_unit_chk #(
  parameter logic [31:0] BASE_VEC = 32'h0,
  parameter bit          HAS_MMU  = 1'b1
) (
  input logic        clk,
  input logic        rst_a,
  input logic        rst_b,
  input logic [13:0] exc_req,
  input logic [31:0] ex_pc,
  input logic        ex_dslot,
  input logic        ex_imm,
  input logic        flush,
  input logic [31:0] fetch_addr,
  input logic        link_we,
  input logic [31:0] link_data,
  input logic        exc_busy
);
  a_r3_trap_vector: assert property (@(posedge clk) disable iff (rst_a || rst_b)
    (exc_req[3] && !exc_busy) |=> (flush && link_we && fetch_addr == BASE_VEC + 32'h20));

  a_r6_next_instr: assert property (@(posedge clk) disable iff (rst_a || rst_b)
    (exc_req[3:0] == 4'b1000 && !exc_busy && !ex_dslot) |=> link_data == $past(ex_pc) + 32'd4);

  a_r5_reexecute: assert property (@(posedge clk) disable iff (rst_a || rst_b)
    (HAS_MMU && exc_req[0] && !exc_busy && !ex_dslot && !ex_imm) |=> link_data == $past(ex_pc));

  a_r7_masked: assert property (@(posedge clk) disable iff (rst_a || rst_b)
    exc_busy |=> !link_we);

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst_a || rst_b)
    (exc_req == 14'd0) |=> (!flush && $stable(fetch_addr)));
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.BASE_VEC(BASE_VEC), .HAS_MMU(HAS_MMU)) u_chk (
  .clk(clk), .rst_a(rst_a), .rst_b(rst_b), .exc_req(exc_req), .ex_pc(ex_pc),
  .ex_dslot(ex_dslot), .ex_imm(ex_imm), .flush(flush), .fetch_addr(fetch_addr),
  .link_we(link_we), .link_data(link_data), .exc_busy(exc_busy));

// File: tb/exc_vector_unit_test.sv
`timescale 1ns/100ps
module exc_vector_unit_test;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam logic [31:0] MSRV = 32'h0000_0402;

  logic clk = 1'b0;
  logic rst_a = 1'b0, rst_b = 1'b0, ex_dslot = 1'b0, ex_imm = 1'b0, ex_br_imm = 1'b0, exc_ack = 1'b0;
  logic [13:0] exc_req = '0;
  logic [31:0] ex_pc = '0;
  logic flush, link_we, spr_init, exc_busy, esr_dslot;
  logic [31:0] fetch_addr, link_data, msr_init;
  logic [3:0] esr_code;

  always #2.5 clk = ~clk;

  exc_vector_unit #(.BASE_VEC(BASE), .MSR_RESET(MSRV)) uut (
    .clk(clk), .rst_a(rst_a), .rst_b(rst_b), .exc_req(exc_req), .ex_pc(ex_pc),
    .ex_dslot(ex_dslot), .ex_imm(ex_imm), .ex_br_imm(ex_br_imm), .exc_ack(exc_ack),
    .flush(flush), .fetch_addr(fetch_addr), .link_we(link_we), .link_data(link_data),
    .spr_init(spr_init), .msr_init(msr_init), .exc_busy(exc_busy),
    .esr_code(esr_code), .esr_dslot(esr_dslot));

  typedef struct {
    bit chk; string tag; bit fl; bit lw; logic [31:0] ld; bit ini;
    logic [31:0] fa; bit bz; logic [3:0] cd; bit ds;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] s_fa = '0;
  bit s_bz = 1'b0, s_ds = 1'b0;
  logic [3:0] s_cd = '0;

  task automatic step(input logic ra, rb, input logic [13:0] rq, input logic [31:0] pc,
                      input logic ds, im, bi, ak, input bit chk, input string tag,
                      input bit ef, elw, input logic [31:0] el, input bit ei,
                      input logic [3:0] ec);
    item_t it;
    @(negedge clk);
    rst_a = ra; rst_b = rb; exc_req = rq; ex_pc = pc;
    ex_dslot = ds; ex_imm = im; ex_br_imm = bi; exc_ack = ak;
    if (ei) begin s_fa = BASE; s_bz = 0; s_cd = 0; s_ds = 0; end
    else if (elw) begin s_fa = BASE + 32'h20; s_bz = 1; s_cd = ec; s_ds = ds; end
    else if (ak) s_bz = 0;
    it = '{chk, tag, ef, elw, el, ei, s_fa, s_bz, s_cd, s_ds};
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 14'd0, 32'h0, 0, 0, 0, 0, 1, tag, 0, 0, 0, 0, 0);
  endtask

  task automatic trap(input logic [13:0] rq, input logic [31:0] pc, input logic ds, im, bi,
                      input string tag, input logic [31:0] el, input logic [3:0] ec);
    step(0, 0, rq, pc, ds, im, bi, 0, 1, tag, 1, 1, el, 0, ec);
    step(0, 0, 14'd0, 32'h0, 0, 0, 0, 1, 1, tag, 0, 0, 0, 0, 0);
  endtask

  task automatic fail(input string tag, input string what, input logic [31:0] act, exp);
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() != 0) begin
        item_t it;
        bit bad;
        it = q.pop_front();
        if (it.chk) begin
          bad = 0;
          checks++;
          if (flush !== it.fl) begin bad = 1; fail(it.tag, "flush", 32'(flush), 32'(it.fl)); end
          if (link_we !== it.lw) begin bad = 1; fail(it.tag, "link_we", 32'(link_we), 32'(it.lw)); end
          if (it.lw && link_data !== it.ld) begin bad = 1; fail(it.tag, "link_data", link_data, it.ld); end
          if (spr_init !== it.ini) begin bad = 1; fail(it.tag, "spr_init", 32'(spr_init), 32'(it.ini)); end
          if (it.ini && msr_init !== MSRV) begin bad = 1; fail(it.tag, "msr_init", msr_init, MSRV); end
          if (fetch_addr !== it.fa) begin bad = 1; fail(it.tag, "fetch_addr", fetch_addr, it.fa); end
          if (exc_busy !== it.bz) begin bad = 1; fail(it.tag, "exc_busy", 32'(exc_busy), 32'(it.bz)); end
          if (esr_code !== it.cd) begin bad = 1; fail(it.tag, "esr_code", 32'(esr_code), 32'(it.cd)); end
          if (esr_dslot !== it.ds) begin bad = 1; fail(it.tag, "esr_dslot", 32'(esr_dslot), 32'(it.ds)); end
          if (bad) errors++;
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1", 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1", 0, 0, 0, 0, 0);
    for (int k = 1; k <= 15; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1", 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R2", 1, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R2", 1, 0, 0, 1, 0);
    step(1, 0, 14'h0008, 32'h40, 0, 0, 0, 0, 1, "R2", 1, 0, 0, 1, 0);
    idle("R10");
    idle("R10");
    trap(14'h0008, 32'h100, 0, 0, 0, "R3", 32'h104, 4'd3);
    step(0, 0, 14'h0008, 32'h150, 0, 0, 0, 0, 1, "R3", 1, 1, 32'h154, 0, 4'd3);
    step(0, 0, 14'h0004, 32'h160, 0, 0, 0, 0, 1, "R7", 0, 0, 0, 0, 0);
    step(0, 0, 14'h0000, 32'h0, 0, 0, 0, 1, 1, "R7", 0, 0, 0, 0, 0);
    trap(14'h0049, 32'h200, 0, 1, 0, "R4", 32'h1FC, 4'd0);
    trap(14'h0010, 32'h300, 1, 0, 1, "R5", 32'h2F8, 4'd4);
    trap(14'h0020, 32'h400, 0, 0, 0, "R5", 32'h400, 4'd5);
    trap(14'h0002, 32'h480, 1, 1, 0, "R8", 32'h47C, 4'd1);
    trap(14'h00C0, 32'h500, 1, 0, 0, "R6", 32'h4FC, 4'd6);
    trap(14'h0800, 32'h600, 0, 1, 0, "R6", 32'h604, 4'd11);
    step(0, 0, 14'h0100, 32'h680, 0, 0, 0, 0, 1, "R9", 0, 0, 0, 0, 0);
    idle("R9");
    step(0, 0, 14'h0500, 32'h700, 0, 0, 0, 0, 1, "R9", 1, 1, 32'h704, 0, 4'd10);
    for (int k = 1; k <= 15; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R1", 0, 0, 0, 0, 0);
    idle("R1");
    for (int k = 1; k <= 15; k++) step(0, 1, 0, 0, 0, 0, 0, 0, 1, "R1", 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, "R2", 1, 0, 0, 1, 0);
    idle("R10");
    trap(14'h2000, 32'h900, 1, 0, 1, "R6", 32'h8F8, 4'd13);
    idle("R10");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule